// File: doc/BRIEF.md
# Circular Delay-Line Address Generator

This block produces the byte address that an audio effects processor uses for its external delay memory. During a sample pass it runs through a fixed number of program steps, one step per clock cycle. For each step it takes that step's memory-request flags, a slot number into a table of 64 base word addresses, and the address-modifier flags. It returns a registered byte address with a read strobe and a write strobe. It also returns the two indices of the four-entry holding queue that the surrounding datapath uses for read data and for writes into its input registers.

Circular buffering comes from a per-sample down-counter. In ring mode the counter is added to every word address, and the sum is wrapped by the ring-length mask. The counter moves once at the end of each pass, so a fixed program offset points one word further into the past on every sample. In absolute mode the counter is left out and the address wraps at 16 bits. A 12-bit offset register can be loaded from the shifter output or from the input bus and added to later addresses. The ring length and the ring byte offset are configured while the block is idle.

A three-state machine controls the pass:
- IDLE waits. A pulse on `sample_go` moves it to RUN with the step count at 0.
- RUN handles one step per cycle. It stays in RUN until the last step, then moves to ROTATE.
- ROTATE updates the down-counter for one cycle and returns to IDLE.

Top module: `ringaddr_gen`

## Requirements
- R1: After reset the block is in IDLE with `busy` low. `acc_rd` and `acc_wr` are low and `dec_count` is 1. The ring length is 32768 words (`ring_log2` = 15), the ring byte offset is 0 and every table entry is 0.
- R2: A `sample_go` pulse in IDLE starts a pass of 128 steps. Step s is handled in the s-th cycle after the go edge. One ROTATE cycle follows, and `busy` is high from the go edge until the ROTATE cycle ends.
- R3: `acc_rd` (or `acc_wr`) is high in the cycle after step s only if step s is odd and `op_rd` (or `op_wr`) was set at that step. Requests on even steps give no strobe.
- R4: In ring mode (`op_abs` = 0) the word address is the table entry at `op_slot`, plus the offset register when `op_add_areg` = 1, plus 1 when `op_plus1` = 1, plus `dec_count`. This sum is ANDed with (2^`ring_log2` − 1). `acc_addr` is twice the word address plus the ring byte offset, truncated to 24 bits.
- R5: In absolute mode (`op_abs` = 1) `dec_count` is not added and the word address wraps modulo 65536. The byte address is then formed as in R4.
- R6: In the ROTATE cycle `dec_count` decreases by 1. When the decrement would reach 0, it reloads with the ring length 2^`ring_log2` instead. It does not change at any other time.
- R7: At a step with `op_areg_load` = 1, the offset register loads `shift_top` (shifter bits 23:12) when `op_shift3` = 1. Otherwise it loads `inputs_top` (input bits 23:16) sign-extended to 12 bits. The load happens on even and odd steps alike.
- R8: An address at a step that also loads the offset register uses the register value from before that load.
- R9: In the cycle after step s, `inq_slot` = s mod 4 and `rdq_slot` = (s + 2) mod 4.
- R10: `tab_we` and `ring_we` have no effect while `busy` is high. Table, ring length and ring offset keep their values for later passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tab_we | input | 1 | Write a base-address table entry (IDLE only) |
| tab_idx | input | 6 | Table entry to write |
| tab_word | input | 16 | Base word address to store |
| ring_we | input | 1 | Write the ring configuration (IDLE only) |
| ring_log2 | input | 4 | Ring length as log2 of words |
| ring_base | input | 24 | Ring byte offset |
| sample_go | input | 1 | Start a pass |
| op_rd | input | 1 | Step requests a memory read |
| op_wr | input | 1 | Step requests a memory write |
| op_abs | input | 1 | Absolute (table) addressing for this step |
| op_add_areg | input | 1 | Add the offset register |
| op_plus1 | input | 1 | Add one word |
| op_slot | input | 6 | Base-address table slot |
| op_areg_load | input | 1 | Load the offset register at this step |
| op_shift3 | input | 1 | Shifter is in saturation-free /4 mode; selects the load source |
| shift_top | input | 12 | Shifter output bits 23:12 |
| inputs_top | input | 8 | Input bus bits 23:16 |
| busy | output | 1 | Pass in progress (RUN or ROTATE) |
| dec_count | output | 16 | Per-sample down-counter |
| acc_addr | output | 24 | Byte address of the last access |
| acc_rd | output | 1 | Read strobe |
| acc_wr | output | 1 | Write strobe |
| rdq_slot | output | 2 | Holding-queue entry that receives read data |
| inq_slot | output | 2 | Holding-queue entry for an input-register write |

## Verification
If the down-counter held a wrong value, every ring-mode address of the next pass would be offset by the error. That would show on `acc_addr` at the first odd access step, and `dec_count` itself would show it one cycle after ROTATE. A step counter out of phase would put strobes on even steps and skew `inq_slot` and `rdq_slot`, which is visible in the cycle after the first step. A wrong offset-register value stays hidden until a later step adds it, and then it appears as a fixed address error.

// File: rtl/ringaddr_pkg.sv
package ringaddr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_ROTATE = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic abs_mode;
        logic add_areg;
        logic plus1;
    } mem_op_t;

endpackage

// File: rtl/ringaddr_ctl.sv
module ringaddr_ctl
    import ringaddr_pkg::*;
#(
    parameter int STEPS  = 128,
    localparam int STEP_W = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    output logic              busy_o,
    output logic              run_o,
    output logic              rotate_o,
    output logic [STEP_W-1:0] step_o
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

    seq_state_t        state_q, state_d;
    logic [STEP_W-1:0] step_q,  step_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        unique case (state_q)
            ST_IDLE: begin
                step_d = '0;
                if (go_i) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (step_q == LAST_STEP) begin
                    state_d = ST_ROTATE;
                    step_d  = '0;
                end else begin
                    step_d  = step_q + 1'b1;
                end
            end
            ST_ROTATE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o   = (state_q != ST_IDLE);
        run_o    = (state_q == ST_RUN);
        rotate_o = (state_q == ST_ROTATE);
        step_o   = step_q;
    end

    // R2: ROTATE lasts exactly one cycle
    a_r2_rotate_once: assert property (@(posedge clk) disable iff (!rst_n)
        rotate_o |=> (state_q == ST_IDLE));

    // R2: a pass always begins at step 0
    a_r2_start_step0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_o) |-> (step_q == '0));

endmodule

// File: rtl/ringaddr_decct.sv
module ringaddr_decct #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rotate_i,
    input  logic [CNT_W-1:0] len_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(1);
        end else if (rotate_i) begin
            if (cnt_q == CNT_W'(1)) cnt_q <= len_i;
            else                    cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    // R6: counter never rests at zero
    a_r6_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != '0);

    // R6: counter moves only after a ROTATE cycle
    a_r6_moves_on_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_q) |-> $past(rotate_i));

endmodule

// File: rtl/ringaddr_table.sv
module ringaddr_table #(
    parameter int SLOTS  = 64,
    parameter int WORD_W = 16,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [SLOT_W-1:0] widx_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [SLOT_W-1:0] ridx_i,
    output logic [WORD_W-1:0] rdata_o
);

    logic [WORD_W-1:0] ent_q [SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) ent_q[i] <= '0;
        end else if (we_i) begin
            ent_q[widx_i] <= wdata_i;
        end
    end

    assign rdata_o = ent_q[ridx_i];

endmodule

// File: rtl/ringaddr_calc.sv
module ringaddr_calc
    import ringaddr_pkg::*;
#(
    parameter int STEP_W  = 7,
    parameter int WORD_W  = 16,
    parameter int AREG_W  = 12,
    parameter int IN_HI_W = 8,
    parameter int BYTE_AW = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic [STEP_W-1:0]  step_i,
    input  mem_op_t            op_i,
    input  logic               areg_load_i,
    input  logic               shift3_i,
    input  logic [AREG_W-1:0]  shift_top_i,
    input  logic [IN_HI_W-1:0] inputs_top_i,
    input  logic [WORD_W-1:0]  tab_word_i,
    input  logic [WORD_W-1:0]  dec_i,
    input  logic [WORD_W-1:0]  ring_mask_i,
    input  logic [BYTE_AW-1:0] ring_base_i,
    output logic [BYTE_AW-1:0] addr_o,
    output logic               rd_o,
    output logic               wr_o,
    output logic [1:0]         rdq_o,
    output logic [1:0]         inq_o
);

    localparam int SUM_W = WORD_W + 2;

    logic [AREG_W-1:0]  areg_q, areg_d;
    logic [SUM_W-1:0]   sum;
    logic [WORD_W-1:0]  word;
    logic [BYTE_AW-1:0] byte_addr;
    logic               access;

    logic [BYTE_AW-1:0] addr_q;
    logic               rd_q, wr_q;
    logic [1:0]         rdq_q, inq_q;

    always_comb begin
        sum = SUM_W'(tab_word_i);
        if (op_i.add_areg) sum = sum + SUM_W'(areg_q);
        if (op_i.plus1)    sum = sum + SUM_W'(1);
        if (!op_i.abs_mode) sum = sum + SUM_W'(dec_i);
        word      = sum[WORD_W-1:0] & (op_i.abs_mode ? {WORD_W{1'b1}} : ring_mask_i);
        byte_addr = BYTE_AW'({word, 1'b0}) + ring_base_i;
        access    = run_i && step_i[0] && (op_i.rd || op_i.wr);
        if (shift3_i) areg_d = shift_top_i;
        else          areg_d = {{(AREG_W-IN_HI_W){inputs_top_i[IN_HI_W-1]}}, inputs_top_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            areg_q <= '0;
            addr_q <= '0;
            rd_q   <= 1'b0;
            wr_q   <= 1'b0;
            rdq_q  <= 2'd2;
            inq_q  <= 2'd0;
        end else begin
            rd_q <= access && op_i.rd;
            wr_q <= access && op_i.wr;
            if (access) addr_q <= byte_addr;
            if (run_i) begin
                inq_q <= step_i[1:0];
                rdq_q <= step_i[1:0] + 2'd2;
                if (areg_load_i) areg_q <= areg_d;
            end
        end
    end

    assign addr_o = addr_q;
    assign rd_o   = rd_q;
    assign wr_o   = wr_q;
    assign rdq_o  = rdq_q;
    assign inq_o  = inq_q;

    // R3: strobes only after odd steps
    a_r3_odd_only: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q || wr_q) |-> inq_q[0]);

    // R7: offset register holds when no load is requested
    a_r7_areg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_i && areg_load_i) |=> $stable(areg_q));

endmodule

// File: rtl/ringaddr_gen.sv
module ringaddr_gen
    import ringaddr_pkg::*;
#(
    parameter int STEPS        = 128,
    parameter int SLOTS        = 64,
    parameter int WORD_W       = 16,
    parameter int AREG_W       = 12,
    parameter int IN_HI_W      = 8,
    parameter int BYTE_AW      = 24,
    parameter int LOG2_W       = 4,
    parameter int DEFAULT_LOG2 = 15,
    localparam int SLOT_W      = $clog2(SLOTS),
    localparam int STEP_W      = $clog2(STEPS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tab_we,
    input  logic [SLOT_W-1:0]  tab_idx,
    input  logic [WORD_W-1:0]  tab_word,
    input  logic               ring_we,
    input  logic [LOG2_W-1:0]  ring_log2,
    input  logic [BYTE_AW-1:0] ring_base,
    input  logic               sample_go,
    input  logic               op_rd,
    input  logic               op_wr,
    input  logic               op_abs,
    input  logic               op_add_areg,
    input  logic               op_plus1,
    input  logic [SLOT_W-1:0]  op_slot,
    input  logic               op_areg_load,
    input  logic               op_shift3,
    input  logic [AREG_W-1:0]  shift_top,
    input  logic [IN_HI_W-1:0] inputs_top,
    output logic               busy,
    output logic [WORD_W-1:0]  dec_count,
    output logic [BYTE_AW-1:0] acc_addr,
    output logic               acc_rd,
    output logic               acc_wr,
    output logic [1:0]         rdq_slot,
    output logic [1:0]         inq_slot
);

    logic               busy_w, run_w, rotate_w;
    logic [STEP_W-1:0]  step_w;
    logic [LOG2_W-1:0]  log2_q;
    logic [BYTE_AW-1:0] base_q;
    logic [WORD_W-1:0]  ring_len, ring_mask, tab_rd;
    mem_op_t            op;

    ringaddr_ctl #(.STEPS(STEPS)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (sample_go),
        .busy_o   (busy_w),
        .run_o    (run_w),
        .rotate_o (rotate_w),
        .step_o   (step_w)
    );

    // ring configuration, writable only while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            log2_q <= LOG2_W'(DEFAULT_LOG2);
            base_q <= '0;
        end else if (ring_we && !busy_w) begin
            log2_q <= ring_log2;
            base_q <= ring_base;
        end
    end

    assign ring_len  = WORD_W'(1) << log2_q;
    assign ring_mask = ring_len - 1'b1;

    ringaddr_table #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_tab (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (tab_we && !busy_w),
        .widx_i  (tab_idx),
        .wdata_i (tab_word),
        .ridx_i  (op_slot),
        .rdata_o (tab_rd)
    );

    ringaddr_decct #(.CNT_W(WORD_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .rotate_i (rotate_w),
        .len_i    (ring_len),
        .cnt_o    (dec_count)
    );

    assign op = '{rd: op_rd, wr: op_wr, abs_mode: op_abs,
                  add_areg: op_add_areg, plus1: op_plus1};

    ringaddr_calc #(
        .STEP_W(STEP_W), .WORD_W(WORD_W), .AREG_W(AREG_W),
        .IN_HI_W(IN_HI_W), .BYTE_AW(BYTE_AW)
    ) u_calc (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run_w),
        .step_i       (step_w),
        .op_i         (op),
        .areg_load_i  (op_areg_load),
        .shift3_i     (op_shift3),
        .shift_top_i  (shift_top),
        .inputs_top_i (inputs_top),
        .tab_word_i   (tab_rd),
        .dec_i        (dec_count),
        .ring_mask_i  (ring_mask),
        .ring_base_i  (base_q),
        .addr_o       (acc_addr),
        .rd_o         (acc_rd),
        .wr_o         (acc_wr),
        .rdq_o        (rdq_slot),
        .inq_o        (inq_slot)
    );

    assign busy = busy_w;

    // R10: ring configuration frozen during a pass
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_w |=> ($stable(log2_q) && $stable(base_q)));

endmodule

// File: tb/ringaddr_gen_tb_top.sv
module ringaddr_gen_tb_top;

    localparam int NS = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tab_we = 0, ring_we = 0, sample_go = 0;
    logic [5:0]  tab_idx = 0, op_slot = 0;
    logic [15:0] tab_word = 0;
    logic [3:0]  ring_log2 = 0;
    logic [23:0] ring_base = 0;
    logic        op_rd = 0, op_wr = 0, op_abs = 0, op_add_areg = 0, op_plus1 = 0;
    logic        op_areg_load = 0, op_shift3 = 0;
    logic [11:0] shift_top = 0;
    logic [7:0]  inputs_top = 0;
    logic        busy, acc_rd, acc_wr;
    logic [15:0] dec_count;
    logic [23:0] acc_addr;
    logic [1:0]  rdq_slot, inq_slot;

    always #5 clk = ~clk;

    ringaddr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .tab_we(tab_we), .tab_idx(tab_idx), .tab_word(tab_word),
        .ring_we(ring_we), .ring_log2(ring_log2), .ring_base(ring_base),
        .sample_go(sample_go), .op_rd(op_rd), .op_wr(op_wr), .op_abs(op_abs),
        .op_add_areg(op_add_areg), .op_plus1(op_plus1), .op_slot(op_slot),
        .op_areg_load(op_areg_load), .op_shift3(op_shift3), .shift_top(shift_top),
        .inputs_top(inputs_top), .busy(busy), .dec_count(dec_count), .acc_addr(acc_addr),
        .acc_rd(acc_rd), .acc_wr(acc_wr), .rdq_slot(rdq_slot), .inq_slot(inq_slot)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // bench model
    int m_tab [64];
    int m_log2 = 15, m_base = 0, m_dec = 1, m_areg = 0;

    // per-step program
    bit p_rd[NS], p_wr[NS], p_abs[NS], p_add[NS], p_p1[NS], p_ld[NS], p_s3[NS];
    int p_slot[NS], p_sh[NS], p_in[NS];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int s = 0; s < NS; s++) begin
            p_rd[s] = 0; p_wr[s] = 0; p_abs[s] = 0; p_add[s] = 0; p_p1[s] = 0;
            p_ld[s] = 0; p_s3[s] = 0; p_slot[s] = 0; p_sh[s] = 0; p_in[s] = 0;
        end
    endtask

    task automatic cfg_table(input int idx, input int val);
        @(negedge clk);
        tab_we = 1; tab_idx = 6'(idx); tab_word = 16'(val);
        @(negedge clk);
        tab_we = 0;
        m_tab[idx] = val & 16'hFFFF;
    endtask

    task automatic cfg_ring(input int lg, input int base);
        @(negedge clk);
        ring_we = 1; ring_log2 = 4'(lg); ring_base = 24'(base);
        @(negedge clk);
        ring_we = 0;
        m_log2 = lg; m_base = base;
    endtask

    function automatic int exp_addr(input int s);
        int w;
        w = m_tab[p_slot[s]];
        if (p_add[s]) w += m_areg;
        if (p_p1[s])  w += 1;
        if (!p_abs[s]) w += m_dec;
        w = p_abs[s] ? (w & 32'hFFFF) : (w & ((1 << m_log2) - 1));
        return ((w * 2) + m_base) & 32'hFFFFFF;
    endfunction

    // one pass; poke attempts configuration writes while busy (R10)
    task automatic run_sample(input bit poke);
        bit er, ew;
        int ea;
        @(negedge clk); sample_go = 1;
        @(negedge clk); sample_go = 0;
        for (int s = 0; s < NS; s++) begin
            op_rd = p_rd[s]; op_wr = p_wr[s]; op_abs = p_abs[s]; op_add_areg = p_add[s];
            op_plus1 = p_p1[s]; op_slot = 6'(p_slot[s]); op_areg_load = p_ld[s];
            op_shift3 = p_s3[s]; shift_top = 12'(p_sh[s]); inputs_top = 8'(p_in[s]);
            tab_we = poke && (s == 5); tab_idx = 6'd3; tab_word = 16'h0ABC;
            ring_we = poke && (s == 5); ring_log2 = 4'd2; ring_base = 24'h55;
            er = (s % 2 == 1) && p_rd[s];
            ew = (s % 2 == 1) && p_wr[s];
            ea = exp_addr(s);
            if (p_ld[s]) m_areg = p_s3[s] ? (p_sh[s] & 12'hFFF)
                                          : ((p_in[s] & 8'h80) ? (p_in[s] | 32'hF00) : p_in[s]);
            @(negedge clk);
            tab_we = 0; ring_we = 0;
            check(acc_rd == er, "R3", $sformatf("rd strobe step %0d", s), acc_rd, er);
            check(acc_wr == ew, "R3", $sformatf("wr strobe step %0d", s), acc_wr, ew);
            if (er || ew)
                check(acc_addr == 24'(ea), p_abs[s] ? "R5" : "R4",
                      $sformatf("addr step %0d", s), acc_addr, ea);
            if (s % 16 == 1) begin
                check(inq_slot == 2'(s % 4), "R9", "inq_slot", inq_slot, s % 4);
                check(rdq_slot == 2'((s + 2) % 4), "R9", "rdq_slot", rdq_slot, (s + 2) % 4);
                check(busy == 1'b1, "R2", "busy in pass", busy, 1);
            end
        end
        op_rd = 0; op_wr = 0; op_abs = 0; op_add_areg = 0; op_plus1 = 0; op_areg_load = 0;
        check(busy == 1'b1, "R2", "busy in rotate", busy, 1);
        @(negedge clk);
        m_dec = (m_dec == 1) ? (1 << m_log2) : m_dec - 1;
        check(busy == 1'b0, "R2", "idle after rotate", busy, 0);
        check(dec_count == 16'(m_dec), "R6", "dec_count after pass", dec_count, m_dec);
    endtask

    task automatic t_reset();
        check(busy == 0, "R1", "busy", busy, 0);
        check(acc_rd == 0 && acc_wr == 0, "R1", "strobes", {acc_rd, acc_wr}, 0);
        check(dec_count == 16'd1, "R1", "dec_count", dec_count, 1);
    endtask

    task automatic t_ring();
        cfg_ring(10, 24'h1000);
        cfg_table(1, 16'h0100); cfg_table(2, 16'h03F0); cfg_table(4, 16'h7FFF);
        clear_prog();
        p_rd[1] = 1; p_slot[1] = 1;
        p_rd[2] = 1; p_slot[2] = 1;                 // even: no strobe (R3)
        p_wr[3] = 1; p_slot[3] = 2; p_p1[3] = 1;
        p_rd[5] = 1; p_wr[5] = 1; p_slot[5] = 4;
        p_wr[7] = 1; p_slot[7] = 2; p_add[7] = 1;
        p_rd[127] = 1; p_slot[127] = 2;
        run_sample(0);
        run_sample(0);                              // counter now wraps ring (R4)
        run_sample(0);
    endtask

    task automatic t_table();
        cfg_table(5, 16'hFFFF);
        clear_prog();
        p_rd[1] = 1; p_abs[1] = 1; p_slot[1] = 4; p_p1[1] = 1;   // 0x8000
        p_wr[3] = 1; p_abs[3] = 1; p_slot[3] = 5; p_p1[3] = 1;   // wraps to 0
        p_rd[9] = 1; p_abs[9] = 1; p_slot[9] = 1;
        run_sample(0);
    endtask

    task automatic t_areg();
        clear_prog();
        p_ld[1] = 1; p_in[1] = 8'h9C;                       // R7 sign extension
        p_rd[3] = 1; p_add[3] = 1; p_abs[3] = 1;            // R8 old value
        p_ld[3] = 1; p_s3[3] = 1; p_sh[3] = 12'h123;
        p_rd[5] = 1; p_add[5] = 1; p_abs[5] = 1;            // R7 shift source
        p_ld[6] = 1; p_in[6] = 8'h12;                       // load on even step
        p_wr[7] = 1; p_add[7] = 1; p_abs[7] = 1;
        p_rd[9] = 1; p_add[9] = 1;                          // ring mode with offset
        run_sample(0);
    endtask

    task automatic t_dec();
        clear_prog();
        cfg_ring(1, 0);
        for (int k = 0; k < 4; k++) run_sample(0);          // R6 length 2
        cfg_ring(0, 0);
        for (int k = 0; k < 2; k++) run_sample(0);          // R6 length 1
    endtask

    task automatic t_busy_cfg();
        cfg_ring(8, 24'h2000);
        cfg_table(3, 16'h0040);
        clear_prog();
        p_rd[1] = 1; p_slot[1] = 3;
        p_wr[9] = 1; p_slot[9] = 3; p_p1[9] = 1;
        run_sample(1);                                      // R10 pokes ignored
        run_sample(0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) m_tab[i] = 0;
        clear_prog();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_ring();
        t_table();
        t_areg();
        t_dec();
        t_busy_cfg();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule